// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a multi-function I/O controller. Software reaches it through two byte-wide I/O addresses: an index port and a data port. After reset the port is locked. The data port then reads as 0xFF and ignores writes, and every byte written to the index port goes to a key detector. Once a four-byte key has been written to the index port, the port unlocks.

While the port is unlocked, a register is reached by writing its index to the index port and then reading or writing the data port. The registers are:
- a device selector;
- a two-byte chip identifier;
- a revision nibble;
- a control register that relocks the port;
- one bank per logical device, holding a 16-bit base address and an enable bit.

The last key byte depends on which of two base addresses the port has been placed at. A strap input selects the base.

The live base addresses and enable bits leave the block as flat output vectors, for use by the device decoders elsewhere on the chip.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the port is locked (`cfg_mode` = 0), `io_rdata` = 0xFF, all device bases and enables are 0, and the device selector and the index pointer are 0.
- R2: While locked, four consecutive index-port writes of 0x87, 0x01, 0x55, K unlock the port. K is 0x55 when `alt_sel` = 0 and 0xAA when `alt_sel` = 1. `cfg_mode` reads 1 from the clock edge that takes the fourth byte.
- R3: A wrong byte during key entry restarts detection. A wrong byte equal to 0x87 counts as the first key byte of a new attempt.
- R4: While locked, reads of either port return 0xFF, data-port writes change no register, and index-port reads do not disturb key entry.
- R5: While unlocked, an index-port write stores the byte as the index pointer. A write of 0xAA is the one exception: it changes nothing. A read of the index port returns the pointer.
- R6: `io_rdata` is registered. It is loaded at the edge where `io_rd` is high and holds its value otherwise. When a read and a write hit the same cycle, the read returns the value from before the write.
- R7: Index 0x20 reads the high byte of the chip identifier and index 0x21 reads the low byte. Writes to both are ignored.
- R8: Index 0x22 reads the low four bits of the revision, with the upper four bits returned as zero.
- R9: Index 0x07 is the device selector. For a selected device below NUM_DEV, index 0x60 is the base high byte, index 0x61 is the base low byte, and bit 0 of index 0x30 is the enable. For a selected device at or above NUM_DEV, these indexes read 0x00 and writes to them are dropped.
- R10: A data write to index 0x02 with bit 1 set relocks the port and clears the index pointer, and a new key is then needed. Index 0x02 reads as 0x00.
- R11: `dev_base[16*i +: 16]` and `dev_enable[i]` always show device i's bank.
- R12: Unimplemented indexes read 0x00 while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_sel | input | 1 | Strap: 1 when the port sits at the alternate base |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| cfg_mode | output | 1 | 1 while the port is unlocked |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |

## Verification
Two functions can land in the same cycle: a data-port read and a data-port write. This covers an ordinary bank write, and also the relock write to index 0x02. The bench raises both strobes together on one bus cycle. It expects the read to return the value from before the write, and it expects the write to take effect from the next cycle on. The reference model computes the read result before applying the write, and it compares `io_rdata`, `cfg_mode` and every device output on each clock. Random bursts that mix key bytes, relocks and register traffic keep producing such collisions, including key entry straight after a relock.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int KEY_LEN  = 4;
  localparam int STEP_W   = $clog2(KEY_LEN + 1);

  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_EN      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_INERT   = 8'hAA;
  localparam int         EXIT_BIT    = 1;
  localparam logic [7:0] LOCKED_RD   = 8'hFF;

  // Expected key byte at a given position; the last one depends on the base strap.
  function automatic logic [7:0] key_byte(input logic [STEP_W-1:0] step, input logic alt);
    case (step)
      STEP_W'(0): return 8'h87;
      STEP_W'(1): return 8'h01;
      STEP_W'(2): return 8'h55;
      default:    return alt ? 8'hAA : 8'h55;
    endcase
  endfunction

  // Progress after one index-port byte; KEY_LEN means the key is complete.
  function automatic logic [STEP_W-1:0] next_step(input logic [STEP_W-1:0] step,
                                                  input logic [7:0] b, input logic alt);
    if (b == key_byte(step, alt))           return step + STEP_W'(1);
    else if (b == key_byte(STEP_W'(0), alt)) return STEP_W'(1);
    else                                     return STEP_W'(0);
  endfunction
endpackage

// File: rtl/cfgp_key_detect.sv
module cfgp_key_detect
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       key_done
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_nx;

  assign step_nx  = next_step(step_q, wr_byte, alt_sel);
  assign key_done = wr_en && (step_nx == STEP_W'(KEY_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n)        step_q <= '0;
    else if (key_done) step_q <= '0;
    else if (wr_en)    step_q <= step_nx;
  end
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [15:0] base,
  output logic        en,
  output logic [7:0]  rd_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      en   <= 1'b0;
    end else if (wr_en) begin
      case (idx)
        IDX_BASE_HI: base[15:8] <= wdata;
        IDX_BASE_LO: base[7:0]  <= wdata;
        IDX_EN:      en         <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_BASE_HI: rd_byte = base[15:8];
      IDX_BASE_LO: rd_byte = base[7:0];
      IDX_EN:      rd_byte = {7'b0, en};
      default:     rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV  = 8,
  parameter logic [15:0] CHIP_ID  = 16'hC5A3,
  parameter logic [7:0]  CHIP_REV = 8'h35
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alt_sel,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic                  io_addr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_mode,
  output logic [16*NUM_DEV-1:0] dev_base,
  output logic [NUM_DEV-1:0]    dev_enable
);
  logic       idx_wr, data_wr, key_done, exit_cmd;
  logic       mode_q;
  logic [7:0] idx_q, ldn_q, rd_next, bank_byte;
  logic [7:0] bank_rd [NUM_DEV];

  assign idx_wr   = io_wr && !io_addr;
  assign data_wr  = io_wr && io_addr;
  assign exit_cmd = mode_q && data_wr && (idx_q == IDX_CTRL) && io_wdata[EXIT_BIT];
  assign cfg_mode = mode_q;

  cfgp_key_detect u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_sel  (alt_sel),
    .wr_en    (idx_wr && !mode_q),
    .wr_byte  (io_wdata),
    .key_done (key_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
      ldn_q  <= '0;
    end else begin
      if (key_done) mode_q <= 1'b1;
      else if (exit_cmd) begin
        mode_q <= 1'b0;
        idx_q  <= '0;
      end
      if (mode_q && idx_wr && io_wdata != IDX_INERT) idx_q <= io_wdata;
      if (mode_q && data_wr && idx_q == IDX_LDN) ldn_q <= io_wdata;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    logic [15:0] base_w;
    logic        en_w;
    cfgp_dev_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_q && data_wr && ldn_q == 8'(i)),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .base    (base_w),
      .en      (en_w),
      .rd_byte (bank_rd[i])
    );
    assign dev_base[16*i +: 16] = base_w;
    assign dev_enable[i]        = en_w;
  end

  always_comb begin
    bank_byte = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_q == 8'(i)) bank_byte = bank_rd[i];
  end

  always_comb begin
    if (!mode_q)       rd_next = LOCKED_RD;
    else if (!io_addr) rd_next = idx_q;
    else begin
      case (idx_q)
        IDX_LDN:   rd_next = ldn_q;
        IDX_ID_HI: rd_next = CHIP_ID[15:8];
        IDX_ID_LO: rd_next = CHIP_ID[7:0];
        IDX_REV:   rd_next = {4'h0, CHIP_REV[3:0]};
        default:   rd_next = bank_byte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     io_rdata <= LOCKED_RD;
    else if (io_rd) io_rdata <= rd_next;
  end
endmodule

// File: rtl/cfg_port_unlock_chk.sv
module cfg_port_unlock_chk #(
  parameter int NUM_DEV = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic                  io_addr,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  cfg_mode,
  input logic [16*NUM_DEV-1:0] dev_base,
  input logic [NUM_DEV-1:0]    dev_enable,
  input logic                  key_done,
  input logic                  exit_cmd,
  input logic [7:0]            idx_q
);
  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> cfg_mode);
  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(key_done));
  // R10
  exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_cmd |=> !cfg_mode);
  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && io_rd) |=> io_rdata == 8'hFF);
  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && io_wr && io_addr) |=> ($stable(dev_base) && $stable(dev_enable)));
  // R5
  inert_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && io_wr && !io_addr && io_wdata == 8'hAA) |=> ($stable(idx_q) && cfg_mode));
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

bind cfg_port_unlock cfg_port_unlock_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .cfg_mode   (cfg_mode),
  .dev_base   (dev_base),
  .dev_enable (dev_enable),
  .key_done   (key_done),
  .exit_cmd   (exit_cmd),
  .idx_q      (idx_q)
);

// File: tb/cfg_port_unlock_bench.sv
module cfg_port_unlock_bench;
  localparam int          N    = 8;
  localparam logic [15:0] CID  = 16'hC5A3;
  localparam logic [7:0]  CREV = 8'h35;

  logic clk = 0, rst_n = 0, alt_sel = 0;
  logic io_wr = 0, io_rd = 0, io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic cfg_mode;
  logic [16*N-1:0] dev_base;
  logic [N-1:0] dev_enable;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_mode;
  logic [7:0] m_idx, m_ldn, m_rd;
  logic [15:0] m_base [N];
  bit m_en [N];
  logic [7:0] keyq [$];

  cfg_port_unlock #(.NUM_DEV(N), .CHIP_ID(CID), .CHIP_REV(CREV)) u_cfg_port_unlock (
    .clk(clk), .rst_n(rst_n), .alt_sel(alt_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .dev_base(dev_base), .dev_enable(dev_enable));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_reg(input logic [7:0] idx);
    case (idx)
      8'h07: return m_ldn;
      8'h20: return CID[15:8];
      8'h21: return CID[7:0];
      8'h22: return CREV & 8'h0F;
      8'h30: return (m_ldn < N) ? {7'b0, m_en[m_ldn]} : 8'h00;
      8'h60: return (m_ldn < N) ? m_base[m_ldn][15:8] : 8'h00;
      8'h61: return (m_ldn < N) ? m_base[m_ldn][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_idx = 0; m_ldn = 0; m_rd = 8'hFF; keyq.delete();
    for (int i = 0; i < N; i++) begin m_base[i] = 0; m_en[i] = 0; end
  endtask

  task automatic model_op(input bit w, input bit r, input bit a, input logic [7:0] d);
    if (r) m_rd = !m_mode ? 8'hFF : (!a ? m_idx : model_reg(m_idx));
    if (w) begin
      if (!m_mode) begin
        if (!a) begin
          keyq.push_back(d);
          if (keyq.size() > 4) void'(keyq.pop_front());
          if (keyq.size() == 4 && keyq[0] == 8'h87 && keyq[1] == 8'h01 &&
              keyq[2] == 8'h55 && keyq[3] == (alt_sel ? 8'hAA : 8'h55)) begin
            m_mode = 1; keyq.delete();
          end
        end
      end else if (!a) begin
        if (d != 8'hAA) m_idx = d;
      end else begin
        case (m_idx)
          8'h02: if (d[1]) begin m_mode = 0; m_idx = 0; end
          8'h07: m_ldn = d;
          8'h30: if (m_ldn < N) m_en[m_ldn] = d[0];
          8'h60: if (m_ldn < N) m_base[m_ldn][15:8] = d;
          8'h61: if (m_ldn < N) m_base[m_ldn][7:0] = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic op(input bit w, input bit r, input bit a, input logic [7:0] d);
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    model_op(w, r, a, d);
    @(posedge clk);
    #2;
    io_wr = 0; io_rd = 0;
  endtask

  task automatic wr_idx(input logic [7:0] d); op(1, 0, 0, d); endtask
  task automatic wr_dat(input logic [7:0] d); op(1, 0, 1, d); endtask
  task automatic set_reg(input logic [7:0] i, input logic [7:0] d); wr_idx(i); wr_dat(d); endtask

  task automatic rd_expect(input bit a, input logic [7:0] exp, input string tag);
    op(0, 1, a, 8'h00);
    #1 check(io_rdata == exp, tag, io_rdata, exp);
  endtask

  task automatic key(input logic [7:0] last);
    wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(last);
  endtask

  // Reference comparison on every clock, a quarter period after the edge.
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(cfg_mode == m_mode, "R2 cfg_mode", cfg_mode, m_mode);
      check(io_rdata == m_rd, "R6 io_rdata", io_rdata, m_rd);
      for (int i = 0; i < N; i++) begin
        check(dev_base[16*i +: 16] == m_base[i], "R11 dev_base", dev_base[16*i +: 16], m_base[i]);
        check(dev_enable[i] == m_en[i], "R11 dev_enable", dev_enable[i], m_en[i]);
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    check(cfg_mode == 0, "R1 mode", cfg_mode, 0);
    check(io_rdata == 8'hFF, "R1 rdata", io_rdata, 8'hFF);
    check(dev_base == '0 && dev_enable == '0, "R1 banks", dev_enable, 0);

    // R4 locked port
    wr_dat(8'h12);
    rd_expect(1, 8'hFF, "R4 locked data read");
    rd_expect(0, 8'hFF, "R4 locked index read");

    // R2 primary key
    key(8'h55);
    #1 check(cfg_mode == 1, "R2 primary key", cfg_mode, 1);
    wr_idx(8'h20); rd_expect(1, 8'hC5, "R7 id high");
    wr_idx(8'h21); rd_expect(1, 8'hA3, "R7 id low");
    wr_dat(8'h00); rd_expect(1, 8'hA3, "R7 id read-only");
    wr_idx(8'h22); rd_expect(1, 8'h05, "R8 revision nibble");
    wr_idx(8'h21); wr_idx(8'hAA);
    rd_expect(0, 8'h21, "R5 inert index");
    rd_expect(1, 8'hA3, "R5 pointer kept");
    wr_idx(8'h4D); rd_expect(1, 8'h00, "R12 unimplemented");
    wr_idx(8'h02); rd_expect(1, 8'h00, "R10 control reads zero");

    // R9 banks
    set_reg(8'h07, 8'h03);
    set_reg(8'h60, 8'h12); set_reg(8'h61, 8'h34); set_reg(8'h30, 8'h01);
    set_reg(8'h07, 8'h05);
    set_reg(8'h60, 8'hAB); set_reg(8'h61, 8'hCD);
    #1 check(dev_base[16*3 +: 16] == 16'h1234, "R9 bank 3", dev_base[16*3 +: 16], 16'h1234);
    check(dev_base[16*5 +: 16] == 16'hABCD, "R11 bank 5", dev_base[16*5 +: 16], 16'hABCD);
    set_reg(8'h07, 8'h09); set_reg(8'h60, 8'h77);
    rd_expect(1, 8'h00, "R9 out-of-range device");
    set_reg(8'h07, 8'h03); wr_idx(8'h60);
    rd_expect(1, 8'h12, "R9 readback");

    // R6 read and write in one cycle
    op(1, 1, 1, 8'h99);
    #1 check(io_rdata == 8'h12, "R6 read before write", io_rdata, 8'h12);
    rd_expect(1, 8'h99, "R6 write landed");

    // R10 relock
    set_reg(8'h02, 8'h01);
    #1 check(cfg_mode == 1, "R10 bit1 clear keeps mode", cfg_mode, 1);
    wr_idx(8'h02);
    op(1, 1, 1, 8'h02);
    #1 check(io_rdata == 8'h00, "R10 same-cycle read", io_rdata, 0);
    check(cfg_mode == 0, "R10 relocked", cfg_mode, 0);
    rd_expect(1, 8'hFF, "R10 locked after exit");

    // R3 restart rules, alternate base
    alt_sel = 1;
    key(8'h55);
    #1 check(cfg_mode == 0, "R2 wrong last byte at alternate base", cfg_mode, 0);
    wr_idx(8'h87); key(8'hAA);
    #1 check(cfg_mode == 1, "R3 repeated first byte", cfg_mode, 1);
    rd_expect(0, 8'h00, "R10 pointer cleared");
    set_reg(8'h02, 8'h02);
    wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'hAA);
    #1 check(cfg_mode == 1, "R3 0x87 restarts as first", cfg_mode, 1);
    set_reg(8'h02, 8'h02);
    wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h13); wr_idx(8'h55); wr_idx(8'hAA);
    #1 check(cfg_mode == 0, "R3 wrong byte restarts", cfg_mode, 0);

    // Random mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pool [10] = '{8'h87, 8'h01, 8'h55, 8'hAA, 8'h02, 8'h07, 8'h60, 8'h61, 8'h30, 8'h03};
      logic [7:0] d = pool[$urandom_range(0, 9)];
      if (n % 500 == 0) begin @(negedge clk); alt_sel = ~alt_sel; keyq.delete(); end
      op($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, d);
    end
    if (!m_mode) key(alt_sel ? 8'hAA : 8'h55);
    #1 check(cfg_mode == 1, "R2 final unlock", cfg_mode, 1);

    @(posedge clk); #6;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule